// File: doc/BRIEF.md
# Asynchronous SRAM Bank Controller

A clocked host uses this controller to read and write a 32-bit-wide asynchronous static RAM array. The array has two 512K-deep banks, and each bank has four byte-wide devices. Each device has its own active-low select. All eight devices share 19 address lines, one write strobe and one output-enable strobe. By choosing which selects to assert, the controller presents the array as 1M x 32, 2M x 16 or 4M x 8. The host picks the view with a static width input, which is captured once after reset.

Requests arrive on a valid/ready handshake: a write flag, a word address in the chosen width, and write data. The controller then runs a fixed strobe sequence. Each of its cycle counts is derived from a nanosecond figure, rounded up to whole clock periods. Writes keep the address stable while the write strobe is low, and the data driver is enabled only inside the write. Reads sample the bus once the access count has run out and return the data with a one-cycle valid pulse. Every access ends with a turnaround period in which all selects are released.

Top module: `sram_bank_ctrl`

## Requirements
- R1: While reset is asserted, all eight selects, the write strobe and the output-enable strobe are high, the data driver is off, and neither ready nor read-valid is asserted. Ready goes high on the first clock edge after reset is released.
- R2: The width input is sampled on the first clock edge after reset is released: 0 gives 32-bit, 1 gives 16-bit, 2 gives 8-bit, and 3 is treated as 32-bit. Later changes have no effect until the next reset.
- R3: In 32-bit mode, host address bit 19 picks the bank (0 = selects 0..3, 1 = selects 4..7), bits 18:0 form the device address, and all four lanes are used. Select index i (0..3) drives data bits 8i+7:8i of its bank.
- R4: In 16-bit mode, host address bit 20 picks the bank, bit 0 picks lanes 0-1 (value 0) or lanes 2-3 (value 1), and bits 19:1 form the device address. Write data comes from host bits 15:0, and read data returns on bits 15:0 with bits 31:16 zero.
- R5: In 8-bit mode, host address bits 1:0 pick the lane, bit 2 picks the bank, and bits 21:3 form the device address. Data travels on host bits 7:0, and read data bits 31:8 are zero.
- R6: A read holds the selected devices' selects and the output enable low for the access count (3 cycles by default). The read data then appears with read-valid high for exactly one cycle.
- R7: A write asserts the address and the selects at least one cycle before the write strobe falls. The write strobe then stays low for the pulse count (3 cycles by default), and the address does not change while the strobe is low.
- R8: The data driver is enabled only while the output enable is high and a select is low. It is off during the first cycle of the write pulse, on for the rest of the pulse, and on for exactly one more cycle after the strobe rises.
- R9: Selects of the two banks are never low in the same cycle. After every access, all selects stay high for at least the turnaround count (2 cycles by default) before any select falls again.
- R10: A request is accepted only while ready is high. Ready stays low from acceptance until the sequence returns to idle.
- R11: In 32-bit mode, host address bits 21:20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Width select, captured after reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | Host word address in the chosen width |
| req_wdata_i | input | 32 | Write data, low-aligned for narrow widths |
| rsp_rdata_o | output | 32 | Read data, low-aligned and zero-extended |
| rsp_valid_o | output | 1 | One-cycle read data valid |
| sram_addr_o | output | 19 | Shared device address |
| sram_cs_no | output | 8 | Device selects, active low, bank 0 in bits 3:0 |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| dq_oe_o | output | 1 | Data bus driver enable |
| dq_o | output | 32 | Data bus value driven during writes |
| dq_i | input | 32 | Data bus value read back |

## Verification
Most internal faults in this controller show up on the strobe pins within a single access. A sequence counter that is off by one changes the measured low time of the write strobe or the output enable in that same access. A wrong bank or lane decode leaves the data in a device that the behavioural array model can see right away. Reading it back in another width then returns a different word. Faults in turnaround or driver timing are visible in the first cycle in which two banks overlap, the driver runs against an enabled output, or the address moves under a low write strobe.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

  typedef enum logic [1:0] {
    WM_32 = 2'd0,
    WM_16 = 2'd1,
    WM_8  = 2'd2
  } width_mode_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_bank_pkg::*;
#(
  parameter int unsigned PHYS_AW = 19,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 8,
  localparam int unsigned DW      = LANES * LANE_W,
  localparam int unsigned LSEL_W  = $clog2(LANES),
  localparam int unsigned HOST_AW = PHYS_AW + LSEL_W + 1
) (
  input  width_mode_e        mode_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [DW-1:0]      raw_i,
  output logic               bank_o,
  output logic [LANES-1:0]   lane_en_o,
  output logic [PHYS_AW-1:0] phys_o,
  output logic [DW-1:0]      wlanes_o,
  output logic [DW-1:0]      rdata_o
);

  localparam int unsigned HALF = LANES / 2;

  logic [LSEL_W-1:0] lsel;
  assign lsel = addr_i[LSEL_W-1:0];

  always_comb begin
    bank_o    = addr_i[PHYS_AW];
    phys_o    = addr_i[PHYS_AW-1:0];
    lane_en_o = '1;
    wlanes_o  = wdata_i;
    rdata_o   = raw_i;
    unique case (mode_i)
      WM_16: begin
        bank_o    = addr_i[PHYS_AW+1];
        phys_o    = addr_i[PHYS_AW:1];
        lane_en_o = addr_i[0] ? {{HALF{1'b1}}, {HALF{1'b0}}} : {{HALF{1'b0}}, {HALF{1'b1}}};
        wlanes_o  = {2{wdata_i[DW/2-1:0]}};
        rdata_o   = '0;
        rdata_o[DW/2-1:0] = addr_i[0] ? raw_i[DW-1:DW/2] : raw_i[DW/2-1:0];
      end
      WM_8: begin
        bank_o    = addr_i[LSEL_W];
        phys_o    = addr_i[PHYS_AW+LSEL_W:LSEL_W+1];
        lane_en_o = '0;
        rdata_o   = '0;
        for (int l = 0; l < LANES; l++) begin
          wlanes_o[l*LANE_W +: LANE_W] = wdata_i[LANE_W-1:0];
          if (lsel == LSEL_W'(l)) begin
            lane_en_o[l]          = 1'b1;
            rdata_o[LANE_W-1:0]   = raw_i[l*LANE_W +: LANE_W];
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq #(
  parameter int unsigned ACC_CYC = 3,
  parameter int unsigned WP_CYC  = 3,
  parameter int unsigned HZ_CYC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic we_i,
  output logic idle_o,
  output logic cs_act_o,
  output logic oe_act_o,
  output logic we_act_o,
  output logic drive_o,
  output logic sample_o
);

  localparam int unsigned MAXC = (ACC_CYC > WP_CYC) ? ((ACC_CYC > HZ_CYC) ? ACC_CYC : HZ_CYC)
                                                    : ((WP_CYC > HZ_CYC) ? WP_CYC : HZ_CYC);
  localparam int unsigned CW = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WA, S_WP, S_WH, S_HZ} seq_e;

  seq_e          st_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= we_i ? S_WA : S_RD;
          cnt_q <= CW'(ACC_CYC - 1);
        end
        S_RD: if (cnt_zero) begin
          st_q  <= S_HZ;
          cnt_q <= CW'(HZ_CYC - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_WA: begin
          st_q  <= S_WP;
          cnt_q <= CW'(WP_CYC - 1);
        end
        S_WP: if (cnt_zero) st_q <= S_WH;
              else cnt_q <= cnt_q - 1'b1;
        S_WH: begin
          st_q  <= S_HZ;
          cnt_q <= CW'(HZ_CYC - 1);
        end
        S_HZ: if (cnt_zero) st_q <= S_IDLE;
              else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign idle_o   = (st_q == S_IDLE);
  assign cs_act_o = (st_q == S_RD) || (st_q == S_WA) || (st_q == S_WP) || (st_q == S_WH);
  assign oe_act_o = (st_q == S_RD);
  assign we_act_o = (st_q == S_WP);
  // driver waits one cycle after the strobe falls, holds one cycle after it rises
  assign drive_o  = ((st_q == S_WP) && (cnt_q != CW'(WP_CYC - 1))) || (st_q == S_WH);
  assign sample_o = (st_q == S_RD) && cnt_zero;

  // independent pulse-width counters
  logic [CW:0] we_run_q, oe_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q <= '0;
      oe_run_q <= '0;
    end else begin
      we_run_q <= we_act_o ? we_run_q + 1'b1 : '0;
      oe_run_q <= oe_act_o ? oe_run_q + 1'b1 : '0;
    end
  end

  p_wp_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_act_o) |-> (we_run_q >= (CW+1)'(WP_CYC)));

  p_acc_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_act_o) |-> (oe_run_q >= (CW+1)'(ACC_CYC)));

  p_sample_in_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> (oe_run_q == (CW+1)'(ACC_CYC - 1)));

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sram_bank_pkg::*;
#(
  parameter int unsigned PHYS_AW  = 19,
  parameter int unsigned LANES    = 4,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned T_ACC_NS = 12,
  parameter int unsigned T_WP_NS  = 10,
  parameter int unsigned T_DS_NS  = 6,
  parameter int unsigned T_HZ_NS  = 6
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [1:0]                         mode_i,
  input  logic                               req_valid_i,
  output logic                               req_ready_o,
  input  logic                               req_we_i,
  input  logic [PHYS_AW+$clog2(LANES):0]     req_addr_i,
  input  logic [LANES*LANE_W-1:0]            req_wdata_i,
  output logic [LANES*LANE_W-1:0]            rsp_rdata_o,
  output logic                               rsp_valid_o,
  output logic [PHYS_AW-1:0]                 sram_addr_o,
  output logic [2*LANES-1:0]                 sram_cs_no,
  output logic                               sram_we_no,
  output logic                               sram_oe_no,
  output logic                               dq_oe_o,
  output logic [LANES*LANE_W-1:0]            dq_o,
  input  logic [LANES*LANE_W-1:0]            dq_i
);

  localparam int unsigned DW      = LANES * LANE_W;
  localparam int unsigned HOST_AW = PHYS_AW + $clog2(LANES) + 1;
  localparam int unsigned NBANK   = 2;
  localparam int unsigned ACC_CYC = umax(ns2cyc(T_ACC_NS, CLK_NS), 1);
  localparam int unsigned WP_CYC  = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS) + 1);
  localparam int unsigned HZ_CYC  = umax(ns2cyc(T_HZ_NS, CLK_NS), 1);

  width_mode_e        mode_q;
  logic               cfg_done_q;
  logic [HOST_AW-1:0] addr_q;
  logic [DW-1:0]      wdata_q;
  logic [DW-1:0]      rdata_q;
  logic               rvalid_q;

  logic               idle, cs_act, oe_act, we_act, drive, sample, accept;
  logic               bank;
  logic [LANES-1:0]   lane_en;
  logic [DW-1:0]      rdata_map;

  assign req_ready_o = cfg_done_q && idle;
  assign accept      = req_valid_i && req_ready_o;

  // width captured once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= WM_32;
      cfg_done_q <= 1'b0;
    end else if (!cfg_done_q) begin
      mode_q     <= (mode_i == 2'd3) ? WM_32 : width_mode_e'(mode_i);
      cfg_done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= rdata_map;
    end
  end

  sram_strobe_seq #(
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .HZ_CYC  (HZ_CYC)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .we_i     (req_we_i),
    .idle_o   (idle),
    .cs_act_o (cs_act),
    .oe_act_o (oe_act),
    .we_act_o (we_act),
    .drive_o  (drive),
    .sample_o (sample)
  );

  sram_lane_map #(
    .PHYS_AW (PHYS_AW),
    .LANES   (LANES),
    .LANE_W  (LANE_W)
  ) u_map (
    .mode_i    (mode_q),
    .addr_i    (addr_q),
    .wdata_i   (wdata_q),
    .raw_i     (dq_i),
    .bank_o    (bank),
    .lane_en_o (lane_en),
    .phys_o    (sram_addr_o),
    .wlanes_o  (dq_o),
    .rdata_o   (rdata_map)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign sram_cs_no[b*LANES+l] = !(cs_act && (bank == 1'(b)) && lane_en[l]);
    end
  end

  assign sram_we_no  = !we_act;
  assign sram_oe_no  = !oe_act;
  assign dq_oe_o     = drive;
  assign rsp_rdata_o = rdata_q;
  assign rsp_valid_o = rvalid_q;

  // port-level checks
  logic lo_sel, hi_sel;
  assign lo_sel = ~&sram_cs_no[LANES-1:0];
  assign hi_sel = ~&sram_cs_no[2*LANES-1:LANES];

  p_bank_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_sel && hi_sel));

  p_turn_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_sel |-> !$past(hi_sel));

  p_turn_hi_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_sel |-> !$past(lo_sel));

  p_addr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> $stable(sram_addr_o));

  p_sel_before_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> $past(lo_sel || hi_sel));

  p_drv_safe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (sram_oe_no && (lo_sel || hi_sel)));

  p_drv_late_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sram_we_no) |-> !dq_oe_o);

  p_rsp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_busy_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_sel || hi_sel) |-> !req_ready_o);

  p_mode_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cfg_done_q) |-> $stable(mode_q));

endmodule

// File: tb/sim_sram_bank_ctrl.sv
module sim_sram_bank_ctrl;

  // expected cycle counts at 5 ns: ceil(12/5)=3, max(ceil(10/5), ceil(6/5)+1)=3, ceil(6/5)=2
  localparam int ACC_EXP = 3;
  localparam int WP_EXP  = 3;
  localparam int HZ_EXP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        valid = 1'b0;
  logic        ready;
  logic        we = 1'b0;
  logic [21:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [18:0] s_addr;
  logic [7:0]  s_cs_n;
  logic        s_we_n, s_oe_n, dq_oe;
  logic [31:0] dq_out;
  logic [31:0] dq_in = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .req_valid_i(valid), .req_ready_o(ready), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_rdata_o(rdata), .rsp_valid_o(rvalid),
    .sram_addr_o(s_addr), .sram_cs_no(s_cs_n), .sram_we_no(s_we_n), .sram_oe_no(s_oe_n),
    .dq_oe_o(dq_oe), .dq_o(dq_out), .dq_i(dq_in)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural array: key = bank*4+lane in bits 22:19, device address below
  logic [7:0] mem [int unsigned];
  function automatic int unsigned key(input int b, input int l, input logic [18:0] a);
    return (int'(b * 4 + l) << 19) | int'(a);
  endfunction
  function automatic logic [7:0] peek(input int b, input int l, input logic [18:0] a);
    if (mem.exists(key(b, l, a))) return mem[key(b, l, a)];
    return 8'h00;
  endfunction

  logic [7:0]  pend_d [4];
  int          pend_b [4];
  bit          pend_v [4];
  logic [18:0] pend_a;
  bit          prev_we_lo = 0, prev_any = 0, seen_acc = 0;
  logic [18:0] prev_addr = '0;
  int          we_cnt = 0, oe_cnt = 0, gap_cnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) pend_v[l] = 0;
      prev_we_lo = 0; prev_any = 0; seen_acc = 0;
      we_cnt = 0; oe_cnt = 0; gap_cnt = 0;
      dq_in = '0;
    end else begin
      bit any;
      any = (s_cs_n != 8'hFF);
      for (int l = 0; l < 4; l++)
        if (!s_cs_n[l] && !s_cs_n[4+l]) chk(0, "R9 both banks on one lane", l, -1);
      // read drive
      for (int l = 0; l < 4; l++) begin
        dq_in[l*8 +: 8] = 8'h00;
        for (int b = 0; b < 2; b++)
          if (!s_cs_n[b*4+l] && !s_oe_n && s_we_n) dq_in[l*8 +: 8] = peek(b, l, s_addr);
      end
      // write capture and commit
      if (!s_we_n && dq_oe) begin
        for (int b = 0; b < 2; b++)
          for (int l = 0; l < 4; l++)
            if (!s_cs_n[b*4+l]) begin
              pend_d[l] = dq_out[l*8 +: 8]; pend_b[l] = b; pend_v[l] = 1;
            end
        pend_a = s_addr;
      end
      if (s_we_n) begin
        for (int l = 0; l < 4; l++)
          if (pend_v[l]) begin
            mem[key(pend_b[l], l, pend_a)] = pend_d[l];
            pend_v[l] = 0;
          end
      end
      // strobe timing
      if (!s_we_n && !prev_we_lo) begin
        chk(prev_any && (prev_addr == s_addr), "R7 select and address before strobe", prev_any, 1);
        chk(!dq_oe, "R8 driver off in first pulse cycle", dq_oe, 0);
      end
      if (!s_we_n && prev_we_lo && (s_addr != prev_addr))
        chk(0, "R7 address moved under strobe", s_addr, prev_addr);
      if (s_we_n && prev_we_lo) begin
        chk(we_cnt == WP_EXP, "R7 write pulse width", we_cnt, WP_EXP);
        chk(dq_oe && any, "R8 driver hold after strobe", dq_oe, 1);
      end
      if (dq_oe && !s_oe_n) chk(0, "R8 driver against output enable", dq_oe, 0);
      if (dq_oe && s_we_n && !prev_we_lo) chk(0, "R8 driver outside write", dq_oe, 0);
      if (s_oe_n && oe_cnt != 0) chk(oe_cnt == ACC_EXP, "R6 access width", oe_cnt, ACC_EXP);
      if (any && !prev_any) begin
        if (seen_acc) chk(gap_cnt >= HZ_EXP, "R9 turnaround gap", gap_cnt, HZ_EXP);
        seen_acc = 1;
      end
      we_cnt  = !s_we_n ? we_cnt + 1 : 0;
      oe_cnt  = !s_oe_n ? oe_cnt + 1 : 0;
      gap_cnt = any ? 0 : gap_cnt + 1;
      prev_we_lo = !s_we_n;
      prev_any   = any;
      prev_addr  = s_addr;
    end
  end

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    repeat (3) @(negedge clk);
    chk(s_cs_n == 8'hFF && s_we_n && s_oe_n && !dq_oe && !ready && !rvalid,
        "R1 reset outputs", {s_cs_n, s_we_n, s_oe_n, dq_oe, ready, rvalid}, {8'hFF, 5'b11000});
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1 ready after reset", ready, 1);
  endtask

  task automatic issue(input bit w, input logic [21:0] a, input logic [31:0] d);
    while (!ready) @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; we = 1'b0; wdata = 32'hDEAD_0BAD;
    chk(!ready, "R10 ready low while busy", ready, 0);
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] d);
    issue(1'b1, a, d);
    while (!ready) @(negedge clk);
  endtask

  task automatic rd(input logic [21:0] a, input logic [31:0] exp, input string tag);
    int n = 0;
    issue(1'b0, a, 32'h0);
    while (!rvalid && n < 20) begin @(negedge clk); n++; end
    chk(rvalid && rdata == exp, tag, rdata, exp);
    @(negedge clk);
    chk(!rvalid, "R6 read valid one cycle", rvalid, 0);
  endtask

  task automatic t_mode32();
    do_reset(2'd0);
    wr(22'h00005, 32'hA1B2_C3D4);
    wr(22'h80005, 32'h1122_3344);
    rd(22'h00005, 32'hA1B2_C3D4, "R3 read bank0");
    rd(22'h80005, 32'h1122_3344, "R3 read bank1");
    chk(peek(0, 3, 19'h5) == 8'hA1, "R3 bank0 lane3 placement", peek(0, 3, 19'h5), 8'hA1);
    chk(peek(1, 0, 19'h5) == 8'h44, "R3 bank1 lane0 placement", peek(1, 0, 19'h5), 8'h44);
  endtask

  task automatic t_r11_alias();
    rd(22'h300005, 32'hA1B2_C3D4, "R11 high bits ignored on read");
    wr(22'h200007, 32'h0F0E_0D0C);
    rd(22'h000007, 32'h0F0E_0D0C, "R11 high bits ignored on write");
  endtask

  task automatic t_mode16();
    do_reset(2'd1);
    mode = 2'd0; // must not take effect (R2)
    wr(22'h000000, 32'h5555_BEEF);
    wr(22'h000001, 32'h7777_CAFE);
    wr(22'h100002, 32'h9999_1234);
    rd(22'h000000, 32'h0000_BEEF, "R4 low pair");
    rd(22'h000001, 32'h0000_CAFE, "R4 high pair / R2 mode held");
    rd(22'h100002, 32'h0000_1234, "R4 upper bank");
    chk(peek(0, 2, 19'h0) == 8'hFE, "R4 pair 2-3 placement", peek(0, 2, 19'h0), 8'hFE);
    chk(peek(1, 1, 19'h1) == 8'h12, "R4 bank1 address placement", peek(1, 1, 19'h1), 8'h12);
  endtask

  task automatic t_mode8();
    do_reset(2'd2);
    mode = 2'd3;
    wr(22'h000000, 32'hAAAA_AA11);
    wr(22'h000001, 32'h0000_0022);
    wr(22'h000002, 32'h0000_0033);
    wr(22'h000003, 32'h0000_0044);
    wr(22'h000004, 32'hFFFF_FF99);
    wr(22'h000009, 32'h0000_0066);
    rd(22'h000002, 32'h0000_0033, "R5 byte lane2 / R2 mode held");
    rd(22'h000004, 32'h0000_0099, "R5 byte bank1");
    rd(22'h000009, 32'h0000_0066, "R5 byte next address");
    chk(peek(0, 1, 19'h1) == 8'h66, "R5 lane1 address1 placement", peek(0, 1, 19'h1), 8'h66);
  endtask

  task automatic t_cross();
    do_reset(2'd0);
    rd(22'h000000, 32'h4433_2211, "R5 bytes seen as word");
    rd(22'h080000, 32'h0000_0099, "R5 bank1 byte seen as word");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_mode32();
    t_r11_alias();
    t_mode16();
    t_mode8();
    t_cross();
    repeat (4) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule